// File: doc/BRIEF.md
# Per-Core Sleep and Wake Controller

This block tracks whether each of NC processor cores is running, asleep after a wait-for-interrupt, or permanently halted. Each core's pipeline reports the sleep, halt and cross-core interrupt instructions it retires. The block answers with a per-core run enable, a one-cycle request to save the next PC into the core's link register (register 31), and a one-cycle request to load the PC back from that register when the core is woken.

A sleeping core wakes when another core sends it a cross-core interrupt or when its own hardware interrupt line rises. The wake resumes the core at the saved PC, as a return from interrupt does. A cross-core interrupt aimed at a running or halted core has no effect. A halted core leaves that state only through reset. A hardware interrupt taken while the core is running raises a vector request. The vector address of core N is a fixed word, VEC_BASE + N.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset every core is in RUN: state code 0, run enable high, and link-write, PC-restore and vector-request outputs low.
- R2: A core in RUN that retires wfi (without stop) is in WFI (state code 1) in the next cycle, with its run enable low and its link-write output high for exactly that one cycle.
- R3: A cross-core interrupt that targets a core in WFI returns it to RUN in the next cycle, with its PC-restore output high for exactly that cycle and no vector request.
- R4: A cross-core interrupt that targets a core in RUN changes nothing: the state stays 0 and no PC-restore pulse appears.
- R5: A core in RUN that retires stop goes to HALT (state code 2) with run enable low. While in HALT, wfi, cross-core interrupts and hardware interrupts to it are ignored and produce no pulses.
- R6: A cross-core interrupt whose target index is NC or more is dropped and wakes no core.
- R7: Several cross-core interrupts that reach the same sleeping core in one cycle produce one wake: a single one-cycle PC-restore pulse and RUN from the next cycle on.
- R8: When a core retires wfi in the same cycle that a cross-core interrupt targets it, the wfi takes effect and the interrupt is dropped, so the core remains in WFI.
- R9: A hardware interrupt to a core in WFI wakes it exactly as R3 does, with a PC-restore pulse and no vector request.
- R10: A hardware interrupt to a core in RUN leaves it in RUN and raises its vector request for one cycle. The vector address output of core N is VEC_BASE + N (1000 + N by default).
- R11: When stop and wfi are retired by a running core in the same cycle, stop wins: the core enters HALT and no link-write pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wfi_i | input | NC | Per-core strobe: core retired wait-for-interrupt |
| stop_i | input | NC | Per-core strobe: core retired a halt |
| intx_vld_i | input | NC | Per-core strobe: core issues a cross-core interrupt |
| intx_tgt_i | input | NC*TGT_W | Target index for each issuing core, core k in bits [k*TGT_W +: TGT_W] |
| hw_irq_i | input | NC | Per-core external interrupt |
| run_en_o | output | NC | High while the core is in RUN |
| state_o | output | 2*NC | Per-core state code (0 RUN, 1 WFI, 2 HALT), core k in bits [2k +: 2] |
| lr_wr_o | output | NC | Pulse: write next PC into register 31 |
| pc_rst_o | output | NC | Pulse: load PC from register 31 |
| vec_req_o | output | NC | Pulse: take the interrupt vector |
| vec_addr_o | output | NC*ADDR_W | Vector address for each core, core k in bits [k*ADDR_W +: ADDR_W] |

## Verification
The properties assume that a core raises wfi, stop or intx only while it runs, and that the strobes last one cycle, as a real pipeline would. They also assume that interrupt lines to a sleeping core are single-cycle events. The bench drives every strobe for exactly one cycle between idle cycles and resets between scenarios. Its deliberate exceptions are the strobes sent to halted and sleeping cores to show they are ignored. The properties that expect a state change are written to hold for those strobes as well.

// File: rtl/sw_pkg.sv
// Package for the sleep/wake controller.
// Holds the per-core state encoding and a small helper. The encoding is
// visible on state_o, so the numeric values are part of the interface.
package sw_pkg;

    typedef enum logic [1:0] {
        CS_RUN  = 2'd0,
        CS_WFI  = 2'd1,
        CS_HALT = 2'd2
    } core_st_e;

    // True when the state lets the core fetch and execute.
    function automatic logic st_is_running(input core_st_e st);
        return (st == CS_RUN);
    endfunction

endpackage

// File: rtl/sw_intx_router.sv
// Cross-core interrupt router.
// Turns NC (valid, target index) requests into a per-target hit vector.
// Assumes each target index is TGT_W bits wide, so it can name indices at or
// beyond NC. Such indices match no target and are dropped. Several requests
// to one target merge into a single hit bit.
module sw_intx_router #(
    parameter int NC    = 4,
    parameter int TGT_W = 3
) (
    input  logic [NC-1:0]       vld_i,
    input  logic [NC*TGT_W-1:0] tgt_i,
    output logic [NC-1:0]       hit_o
);

    // OR together every valid request whose index names each target.
    always_comb begin
        hit_o = '0;
        for (int t = 0; t < NC; t++) begin
            for (int k = 0; k < NC; k++) begin
                if (vld_i[k] && (tgt_i[k*TGT_W +: TGT_W] == TGT_W'(t))) begin
                    hit_o[t] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sw_core_slot.sv
// Run-state machine for one core.
// RUN -> WFI on wfi (link-register write pulse), RUN -> HALT on stop (stop
// wins over wfi), WFI -> RUN on a cross-core hit or a hardware interrupt
// (PC-restore pulse). A hardware interrupt seen in RUN gives a vector request
// pulse. HALT is left only by reset. Inputs are judged against the state
// held before the edge, which is why a wfi and a hit in the same cycle
// leave the core asleep.
module sw_core_slot
    import sw_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wfi_i,
    input  logic     stop_i,
    input  logic     wake_hit_i,
    input  logic     irq_i,
    output core_st_e state_o,
    output logic     lr_wr_o,
    output logic     pc_rst_o,
    output logic     vec_req_o
);

    core_st_e st_q, st_d;
    logic     lr_wr_d, pc_rst_d, vec_req_d;

    // Next state and the one-cycle pulses that go with each transition.
    always_comb begin
        st_d      = st_q;
        lr_wr_d   = 1'b0;
        pc_rst_d  = 1'b0;
        vec_req_d = 1'b0;
        unique case (st_q)
            CS_RUN: begin
                if (stop_i) begin
                    st_d = CS_HALT;
                end else if (wfi_i) begin
                    st_d    = CS_WFI;
                    lr_wr_d = 1'b1;
                end else if (irq_i) begin
                    vec_req_d = 1'b1;
                end
            end
            CS_WFI: begin
                if (wake_hit_i || irq_i) begin
                    st_d     = CS_RUN;
                    pc_rst_d = 1'b1;
                end
            end
            CS_HALT: begin
                st_d = CS_HALT;
            end
            default: begin
                st_d = CS_RUN;
            end
        endcase
    end

    // State and pulse registers, cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= CS_RUN;
            lr_wr_o   <= 1'b0;
            pc_rst_o  <= 1'b0;
            vec_req_o <= 1'b0;
        end else begin
            st_q      <= st_d;
            lr_wr_o   <= lr_wr_d;
            pc_rst_o  <= pc_rst_d;
            vec_req_o <= vec_req_d;
        end
    end

    assign state_o = st_q;

endmodule

// File: rtl/sleep_wake_ctrl.sv
// Sleep and wake controller for NC cores.
// A router resolves the cross-core interrupts to per-target hits. One state
// slot per core then applies that core's wfi, stop, hit and interrupt
// inputs. Vector addresses are fixed words, VEC_BASE + core index.
// Assumes the strobes come from retiring instructions and last one cycle.
module sleep_wake_ctrl
    import sw_pkg::*;
#(
    parameter int NC       = 4,
    parameter int TGT_W    = $clog2(NC) + 1,
    parameter int ADDR_W   = 16,
    parameter int VEC_BASE = 1000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NC-1:0]        wfi_i,
    input  logic [NC-1:0]        stop_i,
    input  logic [NC-1:0]        intx_vld_i,
    input  logic [NC*TGT_W-1:0]  intx_tgt_i,
    input  logic [NC-1:0]        hw_irq_i,
    output logic [NC-1:0]        run_en_o,
    output logic [2*NC-1:0]      state_o,
    output logic [NC-1:0]        lr_wr_o,
    output logic [NC-1:0]        pc_rst_o,
    output logic [NC-1:0]        vec_req_o,
    output logic [NC*ADDR_W-1:0] vec_addr_o
);

    logic [NC-1:0] intx_hit;

    sw_intx_router #(
        .NC    (NC),
        .TGT_W (TGT_W)
    ) u_router (
        .vld_i (intx_vld_i),
        .tgt_i (intx_tgt_i),
        .hit_o (intx_hit)
    );

    for (genvar k = 0; k < NC; k++) begin : g_core
        core_st_e st;

        sw_core_slot u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .wfi_i      (wfi_i[k]),
            .stop_i     (stop_i[k]),
            .wake_hit_i (intx_hit[k]),
            .irq_i      (hw_irq_i[k]),
            .state_o    (st),
            .lr_wr_o    (lr_wr_o[k]),
            .pc_rst_o   (pc_rst_o[k]),
            .vec_req_o  (vec_req_o[k])
        );

        // Expose the state code and the run enable it implies.
        assign state_o[2*k +: 2] = st;
        assign run_en_o[k]       = st_is_running(st);
        // Fixed vector word for this core.
        assign vec_addr_o[k*ADDR_W +: ADDR_W] = ADDR_W'(VEC_BASE + k);
    end

endmodule

// File: rtl/sleep_wake_chk.sv
// Property checker for sleep_wake_ctrl, attached by bind below.
// Observes the ports plus the router's hit vector, per core.
module sleep_wake_chk #(
    parameter int NC = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NC-1:0]   wfi_i,
    input logic [NC-1:0]   stop_i,
    input logic [NC-1:0]   hw_irq_i,
    input logic [NC-1:0]   intx_hit,
    input logic [2*NC-1:0] state_o,
    input logic [NC-1:0]   lr_wr_o,
    input logic [NC-1:0]   pc_rst_o,
    input logic [NC-1:0]   vec_req_o
);

    for (genvar i = 0; i < NC; i++) begin : g_chk
        logic [1:0] st;
        assign st = state_o[2*i +: 2];

        a_r2_wfi_sleeps: assert property (@(posedge clk) disable iff (!rst_n)
            (st == 2'd0 && wfi_i[i] && !stop_i[i]) |=> (st == 2'd1 && lr_wr_o[i]));

        a_r3_intx_wakes: assert property (@(posedge clk) disable iff (!rst_n)
            (st == 2'd1 && intx_hit[i]) |=> (st == 2'd0 && pc_rst_o[i] && !vec_req_o[i]));

        a_r4_run_ignores_intx: assert property (@(posedge clk) disable iff (!rst_n)
            (st == 2'd0 && intx_hit[i] && !wfi_i[i] && !stop_i[i]) |=> (st == 2'd0 && !pc_rst_o[i]));

        a_r5_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (st == 2'd2) |=> (st == 2'd2 && !lr_wr_o[i] && !pc_rst_o[i] && !vec_req_o[i]));

        a_r9_irq_wakes: assert property (@(posedge clk) disable iff (!rst_n)
            (st == 2'd1 && hw_irq_i[i]) |=> (st == 2'd0 && pc_rst_o[i] && !vec_req_o[i]));

        a_r11_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (st == 2'd0 && stop_i[i]) |=> (st == 2'd2 && !lr_wr_o[i]));

        a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({lr_wr_o[i], pc_rst_o[i], vec_req_o[i]}));
    end

endmodule

bind sleep_wake_ctrl sleep_wake_chk #(.NC(NC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wfi_i     (wfi_i),
    .stop_i    (stop_i),
    .hw_irq_i  (hw_irq_i),
    .intx_hit  (intx_hit),
    .state_o   (state_o),
    .lr_wr_o   (lr_wr_o),
    .pc_rst_o  (pc_rst_o),
    .vec_req_o (vec_req_o)
);

// File: tb/test_sleep_wake_ctrl.sv
// Directed bench for sleep_wake_ctrl: one task per scenario.
// Inputs change on the falling edge; outputs are sampled 1 ns after the rising edge.
module test_sleep_wake_ctrl;

    localparam int NC     = 4;
    localparam int TGT_W  = 3;
    localparam int ADDR_W = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NC-1:0]        wfi = '0, stop = '0, vld = '0, irq = '0;
    logic [NC*TGT_W-1:0]  tgt = '0;
    logic [NC-1:0]        run_en, lr_wr, pc_rst, vec_req;
    logic [2*NC-1:0]      state;
    logic [NC*ADDR_W-1:0] vec_addr;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    sleep_wake_ctrl #(.NC(NC), .TGT_W(TGT_W), .ADDR_W(ADDR_W), .VEC_BASE(1000)) i_sleep_wake_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wfi_i      (wfi),
        .stop_i     (stop),
        .intx_vld_i (vld),
        .intx_tgt_i (tgt),
        .hw_irq_i   (irq),
        .run_en_o   (run_en),
        .state_o    (state),
        .lr_wr_o    (lr_wr),
        .pc_rst_o   (pc_rst),
        .vec_req_o  (vec_req),
        .vec_addr_o (vec_addr)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One cycle of stimulus, then sample just after the edge.
    task automatic step(input logic [NC-1:0] w, input logic [NC-1:0] s,
                        input logic [NC-1:0] v, input logic [NC*TGT_W-1:0] t,
                        input logic [NC-1:0] q);
        @(negedge clk);
        wfi = w; stop = s; vld = v; tgt = t; irq = q;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        step('0, '0, '0, '0, '0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wfi = '0; stop = '0; vld = '0; tgt = '0; irq = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Target field helper: core k aims at index t.
    function automatic logic [NC*TGT_W-1:0] aim(input int k, input int t);
        logic [NC*TGT_W-1:0] r = '0;
        r[k*TGT_W +: TGT_W] = TGT_W'(t);
        return r;
    endfunction

    task automatic t_reset();
        do_reset();
        #1;
        chk("R1 state", state, 0);
        chk("R1 run_en", run_en, 4'b1111);
        chk("R1 pulses", {lr_wr, pc_rst, vec_req}, 0);
    endtask

    task automatic t_wfi_then_intx();
        do_reset();
        step(4'b0010, '0, '0, '0, '0);
        chk("R2 state", state, 8'b00_00_01_00);
        chk("R2 run_en", run_en, 4'b1101);
        chk("R2 lr_wr", lr_wr, 4'b0010);
        idle();
        chk("R2 lr_wr one cycle", lr_wr, 0);
        step('0, '0, 4'b0001, aim(0, 1), '0);
        chk("R3 state", state, 0);
        chk("R3 pc_rst", pc_rst, 4'b0010);
        chk("R3 no vec", vec_req, 0);
        idle();
        chk("R3 pc_rst one cycle", pc_rst, 0);
    endtask

    task automatic t_intx_to_running();
        do_reset();
        step('0, '0, 4'b0001, aim(0, 2), '0);
        chk("R4 state", state, 0);
        chk("R4 pulses", {lr_wr, pc_rst, vec_req}, 0);
    endtask

    task automatic t_halt();
        do_reset();
        step('0, 4'b1000, '0, '0, '0);
        chk("R5 state", state, 8'b10_00_00_00);
        chk("R5 run_en", run_en, 4'b0111);
        step(4'b1000, '0, 4'b0001, aim(0, 3), 4'b1000);
        chk("R5 ignored state", state, 8'b10_00_00_00);
        chk("R5 ignored pulses", {lr_wr, pc_rst, vec_req}, 0);
        idle();
        chk("R5 still halted", state, 8'b10_00_00_00);
    endtask

    task automatic t_out_of_range();
        do_reset();
        step(4'b0100, '0, '0, '0, '0);
        step('0, '0, 4'b0011, aim(0, 6) | aim(1, 4), '0);
        chk("R6 still asleep", state, 8'b00_01_00_00);
        chk("R6 no wake", pc_rst, 0);
        step('0, '0, 4'b0001, aim(0, 2), '0);
        chk("R6 in-range wakes", state, 0);
    endtask

    task automatic t_multi_hit();
        do_reset();
        step(4'b0001, '0, '0, '0, '0);
        step('0, '0, 4'b1110, aim(1, 0) | aim(2, 0) | aim(3, 0), '0);
        chk("R7 state", state, 0);
        chk("R7 pc_rst", pc_rst, 4'b0001);
        idle();
        chk("R7 single pulse", pc_rst, 0);
        chk("R7 stays run", state, 0);
    endtask

    task automatic t_wfi_with_intx();
        do_reset();
        step(4'b0010, '0, 4'b0001, aim(0, 1), '0);
        chk("R8 asleep", state, 8'b00_00_01_00);
        chk("R8 no wake", pc_rst, 0);
        idle();
        chk("R8 still asleep", state, 8'b00_00_01_00);
    endtask

    task automatic t_irq_wake();
        do_reset();
        step(4'b0100, '0, '0, '0, '0);
        step('0, '0, '0, '0, 4'b0100);
        chk("R9 state", state, 0);
        chk("R9 pc_rst", pc_rst, 4'b0100);
        chk("R9 no vec", vec_req, 0);
    endtask

    task automatic t_irq_running();
        do_reset();
        step('0, '0, '0, '0, 4'b0010);
        chk("R10 state", state, 0);
        chk("R10 vec_req", vec_req, 4'b0010);
        chk("R10 no restore", pc_rst, 0);
        idle();
        chk("R10 vec one cycle", vec_req, 0);
        for (int k = 0; k < NC; k++) begin
            chk("R10 vec_addr", vec_addr[k*ADDR_W +: ADDR_W], 1000 + k);
        end
    endtask

    task automatic t_stop_and_wfi();
        do_reset();
        step(4'b0001, 4'b0001, '0, '0, '0);
        chk("R11 state", state, 8'b00_00_00_10);
        chk("R11 no lr_wr", lr_wr, 0);
    endtask

    initial begin
        #(4 * 200000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_wfi_then_intx();
        t_intx_to_running();
        t_halt();
        t_out_of_range();
        t_multi_hit();
        t_wfi_with_intx();
        t_irq_wake();
        t_irq_running();
        t_stop_and_wfi();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule